// File: doc/BRIEF.md
# Floppy Drive Soft-Switch Controller

This block is the control window of a floppy disk controller. It presents sixteen locations to the processor. Each access changes state according to its address only: the low address bit chooses between clearing and setting the switch it addresses.

The switches are:
- four stepper phase magnets, kept separately for each drive;
- a motor power bit;
- a two-way drive select;
- two mode bits. Their combination chooses one of four actions on an 8-bit data latch: read from the drive, write to the drive, sense write protect, or load from the bus.

Each read returns a value that depends on the parity of the address. An even address returns the latch. An odd address returns zero.

The block drives the per-drive phase magnets and the per-drive motor enables. It also issues one-cycle events when the motor power actually changes state, and a one-cycle write pulse that carries the latch value to the drive. The stepper track arithmetic and the media model live outside this block.

Top module: `fdc_switch_ctrl`

## Requirements
- R1: A read at address 2n (n = 0..3) clears phase n of the selected drive, and a read at 2n+1 sets it. Phase n of drive d appears on `phase_out[4*d+n]`.
- R2: The phase bits of a drive that is not selected keep their value. Selecting that drive again shows the same bits.
- R3: A read at 0x8 turns motor power off and a read at 0x9 turns it on. A read at 0xA selects drive 0 and a read at 0xB selects drive 1. `pwr_en` is one-hot on the selected drive while power is on and all zero while it is off, so changing the select with power on moves power to the new drive.
- R4: `pwr_on_evt` and `pwr_off_evt` pulse high for one cycle only when the power bit actually changes. A repeated power-on or power-off access gives no pulse.
- R5: A read or a write at 0xC/0xD clears/sets `mode_load`. A read or a write at 0xE/0xF clears/sets `mode_write`.
- R6: After an access at 0xC–0xF updates the mode bits, the new mode decides the latch action. With load=0 and write=0 the latch takes `drv_rdata`. With load=1 and write=0 the latch takes the write-protect flag in bit 7 and zeros in the other bits.
- R7: With load=1 and write=1, a write access loads `acc_wdata` into the latch, and a read-only access loads zero. With load=0 and write=1, the block pulses `drv_wr_valid` for one cycle with `drv_wdata` equal to the latch, and the latch keeps its value.
- R8: One cycle after a read strobe, `bus_rdata` holds zero for an odd address. For an even address it holds the latch value as it stands after that access. Cycles without a read leave `bus_rdata` unchanged.
- R9: When `media_present` is low for the selected drive, accesses at 0xC–0xF still update the mode bits. The latch stays unchanged and no write pulse is issued.
- R10: Write strobes at 0x0–0xB have no effect on the phases, the power or the select.
- R11: A synchronous reset clears all phase bits, turns power off, selects drive 0, and clears both mode bits, the latch, `bus_rdata` and all pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 4 | Location within the control window |
| acc_rd | input | 1 | Read strobe, one cycle per access |
| acc_wr | input | 1 | Write strobe, one cycle per access |
| acc_wdata | input | DATA_W | Bus write data |
| drv_rdata | input | DATA_W | Byte read from the selected drive |
| drv_wprot | input | 1 | Write-protect status of the selected drive |
| media_present | input | NUM_DRIVES | Medium inserted, one bit per drive |
| phase_out | output | 4*NUM_DRIVES | Stepper phase magnets, four bits per drive |
| pwr_en | output | NUM_DRIVES | Motor enable per drive |
| pwr_on_evt | output | 1 | One-cycle pulse when power turns on |
| pwr_off_evt | output | 1 | One-cycle pulse when power turns off |
| drv_sel | output | 1 | Currently selected drive |
| mode_load | output | 1 | Mode bit: 1 = load, 0 = shift |
| mode_write | output | 1 | Mode bit: 1 = write, 0 = read |
| drv_wr_valid | output | 1 | One-cycle pulse: send `drv_wdata` to the drive |
| drv_wdata | output | DATA_W | Latch value sent to the drive |
| bus_rdata | output | DATA_W | Read data returned for the last read access |

## Verification
The hardest state to reach from the ports is a mode access while the selected drive has no medium. The bench first steers the mode bits into load-sense, then drops `media_present` for drive 0 only. It then issues a shift-read and a shift-write and shows that the latch (seen via an even read) and the write pulse are both untouched. Per-drive phase retention also needs a sequence: the bench sets phases on drive 0, switches to drive 1 with power on, changes drive 1's phases, then returns and compares both nibbles.

// File: rtl/fdc_sw_pkg.sv
package fdc_sw_pkg;

  typedef enum logic [1:0] {
    ACT_SHIFT_RD = 2'b00,
    ACT_SHIFT_WR = 2'b01,
    ACT_SENSE    = 2'b10,
    ACT_LOAD_WR  = 2'b11
  } latch_act_e;

  localparam int WIN_AW   = 4;
  localparam int N_PHASES = 4;

  function automatic latch_act_e act_of(input logic load_b, input logic write_b);
    return latch_act_e'({load_b, write_b});
  endfunction

endpackage

// File: rtl/fdc_phase_bank.sv
module fdc_phase_bank #(
  parameter int NUM_DRIVES = 2,
  parameter int N_PH       = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       upd,
  input  logic                       sel,
  input  logic [$clog2(N_PH)-1:0]    idx,
  input  logic                       val,
  output logic [NUM_DRIVES*N_PH-1:0] phases
);

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
    localparam logic DSEL = 1'(d);
    logic [N_PH-1:0] ph_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        ph_q <= '0;
      end else if (upd && sel == DSEL && d < 2) begin
        ph_q[idx] <= val;
      end
    end

    assign phases[d*N_PH +: N_PH] = ph_q;
  end

endmodule

// File: rtl/fdc_power_sel.sv
module fdc_power_sel #(
  parameter int NUM_DRIVES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pwr_upd,
  input  logic                  pwr_val,
  input  logic                  sel_upd,
  input  logic                  sel_val,
  output logic                  sel,
  output logic [NUM_DRIVES-1:0] pwr_en,
  output logic                  on_evt,
  output logic                  off_evt
);

  logic power_q, power_d, sel_d;

  always_comb begin
    power_d = pwr_upd ? pwr_val : power_q;
    sel_d   = sel_upd ? sel_val : sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      power_q <= 1'b0;
      sel     <= 1'b0;
      on_evt  <= 1'b0;
      off_evt <= 1'b0;
    end else begin
      power_q <= power_d;
      sel     <= sel_d;
      on_evt  <= power_d & ~power_q;
      off_evt <= ~power_d & power_q;
    end
  end

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_en
    localparam logic DSEL = 1'(d);
    always_ff @(posedge clk) begin
      if (rst) pwr_en[d] <= 1'b0;
      else     pwr_en[d] <= power_d && (sel_d == DSEL) && (d < 2);
    end
  end

endmodule

// File: rtl/fdc_latch_unit.sv
module fdc_latch_unit
  import fdc_sw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_upd,
  input  logic [1:0]        mode_sw,
  input  logic              is_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata_in,
  input  logic              wprot,
  input  logic              media_ok,
  output logic              mode_load,
  output logic              mode_write,
  output logic [DATA_W-1:0] latch_nxt,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] latch_q;
  logic              load_d, write_d, wv_d;
  latch_act_e        act;

  always_comb begin
    load_d    = mode_load;
    write_d   = mode_write;
    latch_nxt = latch_q;
    wv_d      = 1'b0;
    if (mode_upd) begin
      if (mode_sw[1]) write_d = mode_sw[0];
      else            load_d  = mode_sw[0];
    end
    act = act_of(load_d, write_d);
    if (mode_upd && media_ok) begin
      unique case (act)
        ACT_SHIFT_RD: latch_nxt = rdata_in;
        ACT_SHIFT_WR: wv_d      = 1'b1;
        ACT_SENSE:    latch_nxt = {wprot, {(DATA_W-1){1'b0}}};
        ACT_LOAD_WR:  latch_nxt = is_wr ? wdata : '0;
        default:      latch_nxt = latch_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_load  <= 1'b0;
      mode_write <= 1'b0;
      latch_q    <= '0;
      wr_valid   <= 1'b0;
      wr_data    <= '0;
    end else begin
      mode_load  <= load_d;
      mode_write <= write_d;
      latch_q    <= latch_nxt;
      wr_valid   <= wv_d;
      if (wv_d) wr_data <= latch_q;
    end
  end

endmodule

// File: rtl/fdc_switch_ctrl.sv
module fdc_switch_ctrl
  import fdc_sw_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_DRIVES = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [WIN_AW-1:0]              acc_addr,
  input  logic                           acc_rd,
  input  logic                           acc_wr,
  input  logic [DATA_W-1:0]              acc_wdata,
  input  logic [DATA_W-1:0]              drv_rdata,
  input  logic                           drv_wprot,
  input  logic [NUM_DRIVES-1:0]          media_present,
  output logic [NUM_DRIVES*N_PHASES-1:0] phase_out,
  output logic [NUM_DRIVES-1:0]          pwr_en,
  output logic                           pwr_on_evt,
  output logic                           pwr_off_evt,
  output logic                           drv_sel,
  output logic                           mode_load,
  output logic                           mode_write,
  output logic                           drv_wr_valid,
  output logic [DATA_W-1:0]              drv_wdata,
  output logic [DATA_W-1:0]              bus_rdata
);

  logic              hit_phase, hit_pwr, hit_sel, hit_mode;
  logic [DATA_W-1:0] latch_nxt;

  always_comb begin
    hit_phase = acc_rd && !acc_addr[3];
    hit_pwr   = acc_rd && (acc_addr[3:1] == 3'b100);
    hit_sel   = acc_rd && (acc_addr[3:1] == 3'b101);
    hit_mode  = (acc_rd || acc_wr) && (acc_addr[3:2] == 2'b11);
  end

  fdc_phase_bank #(.NUM_DRIVES(NUM_DRIVES), .N_PH(N_PHASES)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .upd    (hit_phase),
    .sel    (drv_sel),
    .idx    (acc_addr[2:1]),
    .val    (acc_addr[0]),
    .phases (phase_out)
  );

  fdc_power_sel #(.NUM_DRIVES(NUM_DRIVES)) u_power (
    .clk     (clk),
    .rst     (rst),
    .pwr_upd (hit_pwr),
    .pwr_val (acc_addr[0]),
    .sel_upd (hit_sel),
    .sel_val (acc_addr[0]),
    .sel     (drv_sel),
    .pwr_en  (pwr_en),
    .on_evt  (pwr_on_evt),
    .off_evt (pwr_off_evt)
  );

  fdc_latch_unit #(.DATA_W(DATA_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .mode_upd   (hit_mode),
    .mode_sw    (acc_addr[1:0]),
    .is_wr      (acc_wr),
    .wdata      (acc_wdata),
    .rdata_in   (drv_rdata),
    .wprot      (drv_wprot),
    .media_ok   (media_present[drv_sel]),
    .mode_load  (mode_load),
    .mode_write (mode_write),
    .latch_nxt  (latch_nxt),
    .wr_valid   (drv_wr_valid),
    .wr_data    (drv_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (acc_rd) bus_rdata <= acc_addr[0] ? '0 : latch_nxt;
  end

endmodule

// File: rtl/fdc_switch_ctrl_chk.sv
module fdc_switch_ctrl_chk #(
  parameter int DATA_W     = 8,
  parameter int NUM_DRIVES = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic [3:0]              acc_addr,
  input logic                    acc_rd,
  input logic                    acc_wr,
  input logic [NUM_DRIVES-1:0]   media_present,
  input logic [NUM_DRIVES*4-1:0] phase_out,
  input logic [NUM_DRIVES-1:0]   pwr_en,
  input logic                    pwr_on_evt,
  input logic                    pwr_off_evt,
  input logic                    drv_sel,
  input logic                    mode_load,
  input logic                    mode_write,
  input logic                    drv_wr_valid,
  input logic [DATA_W-1:0]       bus_rdata
);

  p_odd_zero_r8: assert property (@(posedge clk) disable iff (rst)
    acc_rd && acc_addr[0] |=> bus_rdata == '0);

  p_pwr_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pwr_en));

  p_on_single_r4: assert property (@(posedge clk) disable iff (rst)
    pwr_on_evt |=> !pwr_on_evt);

  p_off_single_r4: assert property (@(posedge clk) disable iff (rst)
    pwr_off_evt |-> pwr_en == '0);

  p_on_enables_r4: assert property (@(posedge clk) disable iff (rst)
    pwr_on_evt |-> pwr_en != '0);

  p_load_set_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_rd || acc_wr) && acc_addr == 4'hD |=> mode_load);

  p_write_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_rd || acc_wr) && acc_addr == 4'hE |=> !mode_write);

  p_wpulse_mode_r7: assert property (@(posedge clk) disable iff (rst)
    drv_wr_valid |-> mode_write && !mode_load);

  p_nomedia_nowr_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_rd || acc_wr) && acc_addr[3:2] == 2'b11 && !media_present[drv_sel] |=> !drv_wr_valid);

  p_low_wr_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    acc_wr && !acc_rd && !acc_addr[3] |=> $stable(phase_out));

endmodule

bind fdc_switch_ctrl fdc_switch_ctrl_chk #(.DATA_W(DATA_W), .NUM_DRIVES(NUM_DRIVES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .acc_addr      (acc_addr),
  .acc_rd        (acc_rd),
  .acc_wr        (acc_wr),
  .media_present (media_present),
  .phase_out     (phase_out),
  .pwr_en        (pwr_en),
  .pwr_on_evt    (pwr_on_evt),
  .pwr_off_evt   (pwr_off_evt),
  .drv_sel       (drv_sel),
  .mode_load     (mode_load),
  .mode_write    (mode_write),
  .drv_wr_valid  (drv_wr_valid),
  .bus_rdata     (bus_rdata)
);

// File: tb/tb_fdc_switch_ctrl.sv
`timescale 1ns/1ps
module tb_fdc_switch_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] acc_addr = 4'h0;
  logic       acc_rd = 1'b0, acc_wr = 1'b0;
  logic [7:0] acc_wdata = 8'h00, drv_rdata = 8'h00;
  logic       drv_wprot = 1'b0;
  logic [1:0] media_present = 2'b11;
  logic [7:0] phase_out, drv_wdata, bus_rdata;
  logic [1:0] pwr_en;
  logic       pwr_on_evt, pwr_off_evt, drv_sel, mode_load, mode_write, drv_wr_valid;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  fdc_switch_ctrl dut (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .drv_rdata(drv_rdata), .drv_wprot(drv_wprot),
    .media_present(media_present), .phase_out(phase_out), .pwr_en(pwr_en),
    .pwr_on_evt(pwr_on_evt), .pwr_off_evt(pwr_off_evt), .drv_sel(drv_sel),
    .mode_load(mode_load), .mode_write(mode_write), .drv_wr_valid(drv_wr_valid),
    .drv_wdata(drv_wdata), .bus_rdata(bus_rdata)
  );

  // rd wr addr wdata rdin wprot media | bus phase pwr {load,write} wv
  localparam int NV = 19;
  localparam logic [45:0] VEC [NV] = '{
    {2'b10, 4'h1, 8'h00, 8'h00, 1'b0, 2'b11, 8'h00, 8'h01, 2'b00, 2'b00, 1'b0}, // R1
    {2'b10, 4'h5, 8'h00, 8'h00, 1'b0, 2'b11, 8'h00, 8'h05, 2'b00, 2'b00, 1'b0}, // R1
    {2'b10, 4'h0, 8'h00, 8'h00, 1'b0, 2'b11, 8'h00, 8'h04, 2'b00, 2'b00, 1'b0}, // R1 R8
    {2'b10, 4'hE, 8'h00, 8'hA5, 1'b0, 2'b11, 8'hA5, 8'h04, 2'b00, 2'b00, 1'b0}, // R6
    {2'b10, 4'hC, 8'h00, 8'h3C, 1'b0, 2'b11, 8'h3C, 8'h04, 2'b00, 2'b00, 1'b0}, // R6
    {2'b10, 4'h8, 8'h00, 8'h00, 1'b0, 2'b11, 8'h3C, 8'h04, 2'b00, 2'b00, 1'b0}, // R3 R8
    {2'b10, 4'h9, 8'h00, 8'h00, 1'b0, 2'b11, 8'h00, 8'h04, 2'b01, 2'b00, 1'b0}, // R3
    {2'b10, 4'hB, 8'h00, 8'h00, 1'b0, 2'b11, 8'h00, 8'h04, 2'b10, 2'b00, 1'b0}, // R3
    {2'b10, 4'h3, 8'h00, 8'h00, 1'b0, 2'b11, 8'h00, 8'h24, 2'b10, 2'b00, 1'b0}, // R2
    {2'b10, 4'hA, 8'h00, 8'h00, 1'b0, 2'b11, 8'h3C, 8'h24, 2'b01, 2'b00, 1'b0}, // R2 R3
    {2'b01, 4'hD, 8'h77, 8'h00, 1'b1, 2'b11, 8'h3C, 8'h24, 2'b01, 2'b10, 1'b0}, // R5 R6
    {2'b10, 4'h4, 8'h00, 8'h00, 1'b0, 2'b11, 8'h80, 8'h20, 2'b01, 2'b10, 1'b0}, // R6
    {2'b01, 4'hF, 8'h5A, 8'h00, 1'b0, 2'b11, 8'h80, 8'h20, 2'b01, 2'b11, 1'b0}, // R7
    {2'b10, 4'h6, 8'h00, 8'h00, 1'b0, 2'b11, 8'h5A, 8'h20, 2'b01, 2'b11, 1'b0}, // R7
    {2'b01, 4'hC, 8'h00, 8'h00, 1'b0, 2'b11, 8'h5A, 8'h20, 2'b01, 2'b01, 1'b1}, // R7
    {2'b10, 4'hE, 8'h00, 8'h11, 1'b0, 2'b11, 8'h11, 8'h20, 2'b01, 2'b00, 1'b0}, // R6
    {2'b10, 4'hD, 8'h00, 8'h00, 1'b0, 2'b11, 8'h00, 8'h20, 2'b01, 2'b10, 1'b0}, // R8
    {2'b10, 4'hE, 8'h00, 8'h00, 1'b1, 2'b11, 8'h80, 8'h20, 2'b01, 2'b10, 1'b0}, // R6
    {2'b10, 4'h8, 8'h00, 8'h00, 1'b0, 2'b11, 8'h80, 8'h20, 2'b00, 2'b10, 1'b0}  // R3
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic r, input logic w, input logic [3:0] a, input logic [7:0] wd);
    @(negedge clk);
    acc_rd = r; acc_wr = w; acc_addr = a; acc_wdata = wd;
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 phase", 16'(phase_out), 16'h00);
    check("R11 pwr", 16'(pwr_en), 16'h0);
    check("R11 mode", 16'({mode_load, mode_write}), 16'h0);
    check("R11 bus", 16'(bus_rdata), 16'h00);

    for (int i = 0; i < NV; i++) begin
      drv_rdata = VEC[i][31:24];
      drv_wprot = VEC[i][23];
      media_present = VEC[i][22:21];
      access(VEC[i][45], VEC[i][44], VEC[i][43:40], VEC[i][39:32]);
      check($sformatf("vec%0d bus R8", i), 16'(bus_rdata), 16'(VEC[i][20:13]));
      check($sformatf("vec%0d phase R1/R2", i), 16'(phase_out), 16'(VEC[i][12:5]));
      check($sformatf("vec%0d pwr R3", i), 16'(pwr_en), 16'(VEC[i][4:3]));
      check($sformatf("vec%0d mode R5", i), 16'({mode_load, mode_write}), 16'(VEC[i][2:1]));
      check($sformatf("vec%0d wpulse R7", i), 16'(drv_wr_valid), 16'(VEC[i][0]));
    end
    drv_wprot = 1'b0;

    // R4 power events
    access(1'b1, 1'b0, 4'h9, 8'h00);
    check("R4 on pulse", 16'(pwr_on_evt), 16'h1);
    @(negedge clk);
    check("R4 on pulse width", 16'(pwr_on_evt), 16'h0);
    access(1'b1, 1'b0, 4'h9, 8'h00);
    check("R4 repeated on", 16'(pwr_on_evt), 16'h0);
    access(1'b1, 1'b0, 4'h8, 8'h00);
    check("R4 off pulse", 16'(pwr_off_evt), 16'h1);
    check("R3 off pwr", 16'(pwr_en), 16'h0);
    access(1'b1, 1'b0, 4'h8, 8'h00);
    check("R4 repeated off", 16'(pwr_off_evt), 16'h0);

    // R10 writes to low window ignored
    access(1'b0, 1'b1, 4'h1, 8'hFF);
    check("R10 phase", 16'(phase_out), 16'h20);
    access(1'b0, 1'b1, 4'h9, 8'hFF);
    check("R10 pwr", 16'(pwr_en), 16'h0);
    access(1'b0, 1'b1, 4'hB, 8'hFF);
    check("R10 sel", 16'(drv_sel), 16'h0);

    // R9 no medium on selected drive 0 (mode is load=1, write=0, latch 80)
    media_present = 2'b10;
    drv_rdata = 8'hFF;
    access(1'b1, 1'b0, 4'hC, 8'h00);
    check("R9 latch kept", 16'(bus_rdata), 16'h80);
    check("R9 mode updated", 16'({mode_load, mode_write}), 16'h0);
    access(1'b0, 1'b1, 4'hF, 8'h00);
    check("R9 no wpulse", 16'(drv_wr_valid), 16'h0);
    media_present = 2'b11;
    access(1'b1, 1'b0, 4'h0, 8'h00);
    check("R9 latch after", 16'(bus_rdata), 16'h80);

    // R7 write pulse data, then read-only load loads zero
    access(1'b0, 1'b1, 4'hC, 8'h00);
    check("R7 wpulse", 16'(drv_wr_valid), 16'h1);
    check("R7 wdata", 16'(drv_wdata), 16'h80);
    @(negedge clk);
    check("R7 wpulse width", 16'(drv_wr_valid), 16'h0);
    access(1'b1, 1'b0, 4'hD, 8'h00);
    access(1'b1, 1'b0, 4'h0, 8'h00);
    check("R7 read-only load", 16'(bus_rdata), 16'h00);

    // R11 reset from a busy state
    access(1'b1, 1'b0, 4'h9, 8'h00);
    access(1'b1, 1'b0, 4'hB, 8'h00);
    access(1'b1, 1'b0, 4'h7, 8'h00);
    access(1'b0, 1'b1, 4'hF, 8'h33);
    access(1'b1, 1'b0, 4'h0, 8'h00);
    check("R11 pre bus", 16'(bus_rdata), 16'h33);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R11 phase", 16'(phase_out), 16'h00);
    check("R11 pwr", 16'(pwr_en), 16'h0);
    check("R11 sel", 16'(drv_sel), 16'h0);
    check("R11 mode", 16'({mode_load, mode_write}), 16'h0);
    check("R11 bus", 16'(bus_rdata), 16'h00);
    access(1'b1, 1'b0, 4'h0, 8'h00);
    check("R11 latch", 16'(bus_rdata), 16'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule